// File: doc/BRIEF.md
# Frame-Sequenced Successive-Approximation Register Controller

This block holds the trial code of a 4-bit successive-approximation converter and sets its pace. A free-running frame is split into five slots of equal length. Each slot is `CYCLES_PER_SLOT` clocks long. In the first four slots the block decides one bit of the code, most significant bit first. It presents each trial code to an external binary-weighted DAC and reads back a one-bit comparator. In the fifth slot the finished code is copied into a separate result register, and a one-cycle strobe marks the copy. Frames repeat without a gap.

The control path is a three-state machine:

- **ST_IDLE**: the block is held here by reset.
- **ST_DECIDE**: the four decision slots.
- **ST_HOLD**: the closing slot.

The transitions are:

- Any state goes to ST_IDLE while reset is high.
- ST_IDLE goes to ST_DECIDE on the first clock after reset is released. This opens a frame.
- ST_DECIDE goes to ST_HOLD on the edge that decides the least significant bit.
- ST_HOLD goes to ST_DECIDE on the frame-wrap edge. This opens the next frame.

A slot timer, a two-flop comparator synchronizer and a per-bit trial register sit under the state machine.

Top module: `sar_frame_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are as follows: `trial_o` and `result_o` are 0, and `start_o` and `valid_o` are low.
- R2: In the first cycle of every frame, `start_o` is high for exactly one cycle and `trial_o` equals binary 1000 (only bit 3 set).
- R3: On the edge that ends the last cycle of slot k (k = 0..3), bit 3-k of `trial_o` takes the synchronized comparator value. A value of 1 means the input is at or above the trial level, and the bit stays set. A value of 0 clears the bit.
- R4: On that same edge, bit 2-k is set to 1 whatever the decision was. Higher bits that are already decided keep their values.
- R5: Each decision uses the level that `cmp_i` had at the clock edge two cycles before the decision edge. The level of `cmp_i` at any other edge has no effect on the result.
- R6: A frame lasts 5 × `CYCLES_PER_SLOT` cycles, and a new frame begins at once after each one ends.
- R7: `result_o` loads `trial_o` on the edge that ends the first cycle of slot 4. `valid_o` is high for exactly the one cycle that follows, so it is high in cycle 4 × `CYCLES_PER_SLOT` + 1 after `start_o`. In that cycle `result_o` equals `trial_o`.
- R8: `result_o` keeps its value from one load to the next, including across the frame wrap and while `trial_o` changes.
- R9: The first frame after reset begins in the cycle after `rst` is sampled low, and `result_o` stays 0 until the first load.
- R10: If the comparator is ideal (it outputs 1 when the input code is at or above `trial_o`), the result equals the input code for all 16 input codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Comparator result, asynchronous to `clk` |
| trial_o | output | W | Trial code driven to the external DAC |
| result_o | output | W | Held conversion result |
| start_o | output | 1 | High in the first cycle of each frame |
| valid_o | output | 1 | One-cycle strobe after the result register loads |

## Verification
On every decision edge, two things land in the trial register at once: the write of the decided bit and the arming of the next lower bit. Input code 0 forces a clear and an arm in every slot, which gives 1000, 0100, 0010, 0001, 0000. Input code 15 keeps every bit, which gives 1000, 1100, 1110, 1111. The bench samples `trial_o` in the last cycle of each slot and compares it with the expected code for that slot.

The frame-wrap edge also carries two actions. It reloads the trial code to 1000 while the result register must hold its value. The bench checks this by watching `result_o` through a whole following frame. During that frame the input code changes, so `trial_o` takes different values.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_HOLD   = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_cmp_sync.sv
module sar_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= 1'b0;
                end else if (g == 0) begin
                    stage_q[g] <= async_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/sar_slot_timer.sv
module sar_slot_timer #(
    parameter int SLOTS = 5,
    parameter int CPS   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    output logic [$clog2(SLOTS)-1:0] slot_o,
    output logic [$clog2(CPS)-1:0]   cyc_o,
    output logic                     slot_end_o,
    output logic                     frame_end_o
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CYC_W  = $clog2(CPS);

    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              last_cyc;
    logic              last_slot;

    assign last_cyc  = (cyc_q == CYC_W'(CPS - 1));
    assign last_slot = (slot_q == SLOT_W'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            slot_q <= '0;
            cyc_q  <= '0;
        end else if (last_cyc) begin
            cyc_q  <= '0;
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    assign slot_o      = slot_q;
    assign cyc_o       = cyc_q;
    assign slot_end_o  = run && last_cyc;
    assign frame_end_o = run && last_cyc && last_slot;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_init,
    input  logic             decide_en,
    input  logic [IDX_W-1:0] decide_idx,
    input  logic             cmp_bit,
    output logic [W-1:0]     trial_o
);

    logic [W-1:0] bits_q;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    bits_q[i] <= 1'b0;
                end else if (load_init) begin
                    bits_q[i] <= (i == W - 1) ? 1'b1 : 1'b0;
                end else if (decide_en) begin
                    if (int'(decide_idx) == i) begin
                        bits_q[i] <= cmp_bit;
                    end else if (int'(decide_idx) == i + 1) begin
                        bits_q[i] <= 1'b1;
                    end
                end
            end
        end
    endgenerate

    assign trial_o = bits_q;

endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
    import sar_pkg::*;
#(
    parameter int W               = 4,
    parameter int CYCLES_PER_SLOT = 4,
    parameter int SYNC_STAGES     = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o,
    output logic         start_o,
    output logic         valid_o
);

    localparam int SLOTS  = W + 1;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CYC_W  = $clog2(CYCLES_PER_SLOT);
    localparam int IDX_W  = (W > 1) ? $clog2(W) : 1;

    sar_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot;
    logic [CYC_W-1:0]  cyc;
    logic              slot_end;
    logic              frame_end;
    logic              cmp_sync;
    logic              frame_open;
    logic              decide_fire;
    logic              publish;
    logic [IDX_W-1:0]  decide_idx;
    logic [W-1:0]      trial;
    logic [W-1:0]      result_q;
    logic              start_q;
    logic              valid_q;

    sar_slot_timer #(
        .SLOTS (SLOTS),
        .CPS   (CYCLES_PER_SLOT)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .run         (state_q != ST_IDLE),
        .slot_o      (slot),
        .cyc_o       (cyc),
        .slot_end_o  (slot_end),
        .frame_end_o (frame_end)
    );

    sar_cmp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cmp_i),
        .sync_o  (cmp_sync)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_DECIDE;
            ST_DECIDE: if (slot_end && slot == SLOT_W'(W - 1)) state_d = ST_HOLD;
            ST_HOLD:   if (frame_end) state_d = ST_DECIDE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign frame_open  = (state_q == ST_IDLE) || (state_q == ST_HOLD && frame_end);
    assign decide_fire = (state_q == ST_DECIDE) && slot_end;
    assign publish     = (state_q == ST_HOLD) && (cyc == '0);
    assign decide_idx  = IDX_W'(W - 1 - int'(slot));

    sar_trial_reg #(
        .W     (W),
        .IDX_W (IDX_W)
    ) u_trial (
        .clk        (clk),
        .rst        (rst),
        .load_init  (frame_open),
        .decide_en  (decide_fire),
        .decide_idx (decide_idx),
        .cmp_bit    (cmp_sync),
        .trial_o    (trial)
    );

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= 1'b0;
            valid_q  <= 1'b0;
            result_q <= '0;
        end else begin
            start_q <= frame_open;
            valid_q <= publish;
            if (publish) begin
                result_q <= trial;
            end
        end
    end

    assign trial_o  = trial;
    assign result_o = result_q;
    assign start_o  = start_q;
    assign valid_o  = valid_q;

endmodule

// File: rtl/sar_frame_ctrl_chk.sv
module sar_frame_ctrl_chk #(
    parameter int W   = 4,
    parameter int CPS = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] trial_o,
    input logic [W-1:0] result_o,
    input logic         start_o,
    input logic         valid_o
);

    localparam int FRAME = (W + 1) * CPS;

    int   since_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= 0;
            seen_q  <= 1'b0;
        end else if (start_o) begin
            since_q <= 0;
            seen_q  <= 1'b1;
        end else begin
            since_q <= since_q + 1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (trial_o == '0 && result_o == '0 && !start_o && !valid_o));

    p_start_code_r2: assert property (@(posedge clk) disable iff (rst)
        start_o |-> trial_o == {1'b1, {(W-1){1'b0}}});

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    p_frame_len_r6: assert property (@(posedge clk) disable iff (rst)
        (start_o && seen_q) |-> since_q == FRAME - 1);

    p_valid_match_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> result_o == trial_o);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_valid_offset_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && seen_q) |-> since_q == W * CPS);

    p_result_held_r8: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o));

    p_first_start_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> start_o);

endmodule

bind sar_frame_ctrl sar_frame_ctrl_chk #(
    .W   (W),
    .CPS (CYCLES_PER_SLOT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trial_o  (trial_o),
    .result_o (result_o),
    .start_o  (start_o),
    .valid_o  (valid_o)
);

// File: tb/sar_frame_ctrl_tb.sv
`timescale 1ns/1ps
module sar_frame_ctrl_tb;

    localparam int W     = 4;
    localparam int CPS   = 4;
    localparam int SYNC  = 2;
    localparam int FRAME = (W + 1) * CPS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmp_i = 1'b0;
    logic [W-1:0] trial_o;
    logic [W-1:0] result_o;
    logic         start_o;
    logic         valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    int vin    = 0;
    bit glitch = 1'b0;
    int pos    = 0;

    always #2.5 clk = ~clk;

    sar_frame_ctrl #(
        .W               (W),
        .CYCLES_PER_SLOT (CPS),
        .SYNC_STAGES     (SYNC)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cmp_i    (cmp_i),
        .trial_o  (trial_o),
        .result_o (result_o),
        .start_o  (start_o),
        .valid_o  (valid_o)
    );

    // Ideal comparator model. Glitch mode inverts it except in the sampled cycle (R5).
    initial begin
        forever begin
            @(negedge clk);
            if (start_o) pos = 0;
            else pos = pos + 1;
            begin
                bit ideal;
                ideal = (vin >= int'(trial_o));
                if (glitch && (pos % CPS) != CPS - 1 - SYNC) cmp_i = !ideal;
                else cmp_i = ideal;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int expect_code(input int v, input int s);
        int code = 0;
        for (int b = W - 1; b >= W - s; b--) begin
            int t = code | (1 << b);
            if (v >= t) code = t;
        end
        if (s < W) code = code | (1 << (W - 1 - s));
        return code;
    endfunction

    task automatic wait_start();
        for (int k = 0; k < 4 * FRAME; k++) begin
            @(negedge clk);
            if (start_o) return;
        end
        check(1'b0, "R6", "start timeout", 0, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(trial_o == 0 && result_o == 0 && !start_o && !valid_o, "R1",
                  "outputs in reset", int'({trial_o, result_o, start_o, valid_o}), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(start_o == 1'b1, "R9", "start after release", int'(start_o), 1);
        check(trial_o == 4'b1000, "R2", "trial at frame start", int'(trial_o), 8);
        @(negedge clk);
        check(start_o == 1'b0, "R2", "start width", int'(start_o), 0);
        check(result_o == 0, "R9", "result before first load", int'(result_o), 0);
    endtask

    task automatic t_convert(input int v, input string req);
        int k;
        wait_start();
        vin = v;
        k = 0;
        while (k < 2 * FRAME) begin
            @(negedge clk);
            k++;
            if (valid_o) break;
        end
        check(k == W * CPS + 1, "R7", "valid offset", k, W * CPS + 1);
        check(int'(result_o) == v, req, "result code", int'(result_o), v);
        check(result_o == trial_o, "R7", "result equals trial", int'(result_o), int'(trial_o));
        @(negedge clk);
        check(!valid_o, "R7", "valid width", int'(valid_o), 0);
    endtask

    task automatic t_steps(input int v);
        wait_start();
        vin = v;
        for (int c = 1; c < FRAME; c++) begin
            @(negedge clk);
            if (c % CPS == CPS - 1) begin
                int s = c / CPS;
                int e = expect_code(v, (s >= W) ? W : s);
                check(int'(trial_o) == e, (s == 0) ? "R4" : "R3",
                      $sformatf("trial in slot %0d for code %0d", s, v), int'(trial_o), e);
            end
        end
    endtask

    task automatic t_hold(input int v);
        int held;
        int bad = 0;
        t_convert(v, "R10");
        held = int'(result_o);
        vin = 15 - v;
        for (int c = 0; c < FRAME - 2; c++) begin
            @(negedge clk);
            if (int'(result_o) != held) bad++;
        end
        check(bad == 0, "R8", "result held across wrap", bad, 0);
    endtask

    task automatic t_period();
        int k = 0;
        wait_start();
        while (k < 3 * FRAME) begin
            @(negedge clk);
            k++;
            if (start_o) break;
        end
        check(k == FRAME, "R6", "frame length", k, FRAME);
    endtask

    task automatic t_midreset();
        wait_start();
        repeat (CPS + 1) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(trial_o == 0 && result_o == 0 && !start_o && !valid_o, "R1",
              "outputs after mid-frame reset", int'({trial_o, result_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(start_o && trial_o == 4'b1000, "R9", "restart after reset",
              int'({start_o, trial_o}), 24);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_period();
        for (int v = 0; v < 16; v++) t_convert(v, "R10");
        t_steps(0);
        t_steps(15);
        t_steps(6);
        glitch = 1'b1;
        t_convert(9, "R5");
        t_convert(6, "R5");
        glitch = 1'b0;
        t_hold(11);
        t_midreset();
        t_convert(3, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule